// File: doc/BRIEF.md
# Accumulator ALU with Condition Codes

This block is the arithmetic datapath of a one-register accumulator machine. Each cycle the controller presents the accumulator value, a memory operand and an operation code, and pulses an execute strobe. One cycle later the block returns the result. A destination bit tells the controller whether the result goes to the accumulator or back to the addressed memory cell.

A compare operation loads a three-flag condition code register (greater, equal, less). It compares the memory operand against the accumulator. The block also turns those flags into a branch-taken signal for a selected jump condition, so the controller's sequencer needs no flag logic of its own.

Top module: `acc_alu_cc`

## Requirements
- R1: After reset the flags read flag_eq=1, flag_gt=0 and flag_lt=0, and res_valid is 0.
- R2: ADD (op_code 2) returns acc_r + mem_opnd and SUB (op_code 3) returns acc_r - mem_opnd. Both wrap modulo 2^W and both give res_to_mem=0.
- R3: LOAD (op_code 0) returns mem_opnd with res_to_mem=0.
- R4: CLEAR (op_code 1) returns 0, INC (op_code 4) returns mem_opnd + 1 and DEC (op_code 5) returns mem_opnd - 1. All three wrap modulo 2^W and give res_to_mem=1.
- R5: An executed CMP (op_code 6) compares mem_opnd against acc_r as unsigned numbers. It sets flag_gt if the operand is larger, flag_eq if they are equal and flag_lt if it is smaller. Exactly one flag is set at all times.
- R6: The flags change only on a cycle where exec_en is high and op_code is CMP. Every other operation, and every cycle with exec_en low, leaves them unchanged.
- R7: jmp_take follows the current flags with no clock delay. jmp_cond 0 selects GT, 1 selects EQ and 2 selects LT.
- R8: jmp_cond 3 (NEQ) is taken when flag_eq is 0, 4 (GE) when flag_gt or flag_eq is set, and 5 (LE) when flag_lt or flag_eq is set. Codes 6 and 7 are never taken.
- R9: A result appears on the cycle after the strobe, and res_valid is high for exactly that one cycle. CMP, the unused op_code 7 and cycles with exec_en low produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_en | input | 1 | Execute strobe for the presented operation |
| op_code | input | 3 | Operation select |
| acc_r | input | W | Accumulator register value |
| mem_opnd | input | W | Memory operand |
| jmp_cond | input | 3 | Jump condition select |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_data | output | W | Result value |
| res_to_mem | output | 1 | 1: result goes to the memory cell, 0: to the accumulator |
| flag_gt | output | 1 | Operand was greater than the accumulator at the last compare |
| flag_eq | output | 1 | Operand was equal to the accumulator at the last compare |
| flag_lt | output | 1 | Operand was less than the accumulator at the last compare |
| jmp_take | output | 1 | Selected jump condition is true |

## Verification
The assertions take exec_en, op_code, acc_r and mem_opnd to be known values at every clock edge once reset is released. They take jmp_cond to be known whenever jmp_take is checked. The stimulus drives every input from time zero and changes them only at falling edges, so each rising edge samples settled values. The stimulus issues an operation with a quiet cycle after it. This makes each result line up with a single expected entry, and lets a stray valid cycle be seen as an unmatched result.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_ADD   = 3'd2,
    OP_SUB   = 3'd3,
    OP_INC   = 3'd4,
    OP_DEC   = 3'd5,
    OP_CMP   = 3'd6,
    OP_NOP   = 3'd7
  } acc_op_e;

  typedef enum logic [2:0] {
    JC_GT    = 3'd0,
    JC_EQ    = 3'd1,
    JC_LT    = 3'd2,
    JC_NEQ   = 3'd3,
    JC_GE    = 3'd4,
    JC_LE    = 3'd5,
    JC_OFF_A = 3'd6,
    JC_OFF_B = 3'd7
  } jmp_cond_e;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } ccr_t;

  localparam ccr_t CCR_RESET = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

  // Branch decision from the stored flags
  function automatic logic cond_eval(ccr_t f, jmp_cond_e c);
    case (c)
      JC_GT:   return f.gt;
      JC_EQ:   return f.eq;
      JC_LT:   return f.lt;
      JC_NEQ:  return !f.eq;
      JC_GE:   return f.gt | f.eq;
      JC_LE:   return f.lt | f.eq;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/acc_arith.sv
module acc_arith
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  acc_op_e      op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] res,
  output logic         to_mem,
  output logic         produces
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  function automatic logic [W-1:0] f_add(logic [W-1:0] a, logic [W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [W-1:0] f_sub(logic [W-1:0] a, logic [W-1:0] b);
    return a - b;
  endfunction

  function automatic logic [W-1:0] f_step(logic [W-1:0] a, logic down);
    return down ? (a - ONE) : (a + ONE);
  endfunction

  always_comb begin
    res      = ZERO;
    to_mem   = 1'b0;
    produces = 1'b1;
    case (op)
      OP_LOAD:  res = opnd;
      OP_ADD:   res = f_add(acc, opnd);
      OP_SUB:   res = f_sub(acc, opnd);
      OP_CLEAR: begin res = ZERO;                 to_mem = 1'b1; end
      OP_INC:   begin res = f_step(opnd, 1'b0);   to_mem = 1'b1; end
      OP_DEC:   begin res = f_step(opnd, 1'b1);   to_mem = 1'b1; end
      default:  produces = 1'b0;
    endcase
  end

endmodule

// File: rtl/acc_ccr.sv
module acc_ccr
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_fire,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  output ccr_t         flags
);

  // Unsigned compare of the operand against the accumulator
  function automatic ccr_t f_compare(logic [W-1:0] a, logic [W-1:0] m);
    ccr_t r;
    r.gt = (m > a);
    r.eq = (m == a);
    r.lt = (m < a);
    return r;
  endfunction

  ccr_t flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= CCR_RESET;
    else if (cmp_fire) flags_q <= f_compare(acc, opnd);
  end

  assign flags = flags_q;

endmodule

// File: rtl/acc_branch.sv
module acc_branch
  import acc_alu_pkg::*;
(
  input  ccr_t       flags,
  input  jmp_cond_e  cond,
  output logic       take
);

  localparam int NCOND = 8;

  logic [NCOND-1:0] truth;

  for (genvar i = 0; i < NCOND; i++) begin : g_cond
    assign truth[i] = cond_eval(flags, jmp_cond_e'(3'(i)));
  end

  assign take = truth[cond];

endmodule

// File: rtl/acc_alu_cc.sv
module acc_alu_cc
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exec_en,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] acc_r,
  input  logic [W-1:0] mem_opnd,
  input  logic [2:0]   jmp_cond,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         res_to_mem,
  output logic         flag_gt,
  output logic         flag_eq,
  output logic         flag_lt,
  output logic         jmp_take
);

  acc_op_e      op;
  logic [W-1:0] arith_res;
  logic         arith_mem;
  logic         arith_prod;
  logic         cmp_fire;   // compare executes this cycle
  logic         res_fire;   // a result is captured this cycle
  ccr_t         flags;

  assign op = acc_op_e'(op_code);

  acc_arith #(.W(W)) u_arith (
    .op       (op),
    .acc      (acc_r),
    .opnd     (mem_opnd),
    .res      (arith_res),
    .to_mem   (arith_mem),
    .produces (arith_prod)
  );

  assign cmp_fire = exec_en && (op == OP_CMP);
  assign res_fire = exec_en && arith_prod;

  acc_ccr #(.W(W)) u_ccr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_fire (cmp_fire),
    .acc      (acc_r),
    .opnd     (mem_opnd),
    .flags    (flags)
  );

  acc_branch u_branch (
    .flags (flags),
    .cond  (jmp_cond_e'(jmp_cond)),
    .take  (jmp_take)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_data   <= '0;
      res_to_mem <= 1'b0;
    end else begin
      res_valid <= res_fire;
      if (res_fire) begin
        res_data   <= arith_res;
        res_to_mem <= arith_mem;
      end
    end
  end

  assign flag_gt = flags.gt;
  assign flag_eq = flags.eq;
  assign flag_lt = flags.lt;

endmodule

// File: rtl/acc_alu_cc_chk.sv
module acc_alu_cc_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         exec_en,
  input logic [2:0]   op_code,
  input logic [W-1:0] acc_r,
  input logic [W-1:0] mem_opnd,
  input logic [2:0]   jmp_cond,
  input logic         res_valid,
  input logic [W-1:0] res_data,
  input logic         res_to_mem,
  input logic         flag_gt,
  input logic         flag_eq,
  input logic         flag_lt,
  input logic         jmp_take,
  input logic         cmp_fire
);

  AST_FLAGS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flag_gt, flag_eq, flag_lt}) == 1);  // R5

  AST_CMP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> (flag_gt == ($past(mem_opnd) > $past(acc_r))) &&
                 (flag_lt == ($past(mem_opnd) < $past(acc_r))));  // R5

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_en && op_code == 3'd6) |=> $stable({flag_gt, flag_eq, flag_lt}));  // R6

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op_code == 3'd2) |=>
      res_valid && !res_to_mem && res_data == W'($past(acc_r) + $past(mem_opnd)));  // R2

  AST_STEP_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && (op_code == 3'd1 || op_code == 3'd4 || op_code == 3'd5)) |=>
      res_valid && res_to_mem);  // R4

  AST_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_en || op_code == 3'd6 || op_code == 3'd7) |=> !res_valid);  // R9

  AST_NEQ_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_cond == 3'd3) |-> (jmp_take == !flag_eq));  // R8

  AST_OFF_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_cond[2:1] == 2'b11) |-> !jmp_take);  // R8

endmodule

bind acc_alu_cc acc_alu_cc_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .exec_en    (exec_en),
  .op_code    (op_code),
  .acc_r      (acc_r),
  .mem_opnd   (mem_opnd),
  .jmp_cond   (jmp_cond),
  .res_valid  (res_valid),
  .res_data   (res_data),
  .res_to_mem (res_to_mem),
  .flag_gt    (flag_gt),
  .flag_eq    (flag_eq),
  .flag_lt    (flag_lt),
  .jmp_take   (jmp_take),
  .cmp_fire   (cmp_fire)
);

// File: tb/tb_acc_alu_cc.sv
`timescale 1ns/1ps
module tb_acc_alu_cc;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         exec_en = 1'b0;
  logic [2:0]   op_code = 3'd7;
  logic [W-1:0] acc_r = '0;
  logic [W-1:0] mem_opnd = '0;
  logic [2:0]   jmp_cond = 3'd0;
  logic         res_valid;
  logic [W-1:0] res_data;
  logic         res_to_mem;
  logic         flag_gt, flag_eq, flag_lt, jmp_take;

  always #2.5 clk = ~clk;

  acc_alu_cc #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_code(op_code),
    .acc_r(acc_r), .mem_opnd(mem_opnd), .jmp_cond(jmp_cond),
    .res_valid(res_valid), .res_data(res_data), .res_to_mem(res_to_mem),
    .flag_gt(flag_gt), .flag_eq(flag_eq), .flag_lt(flag_lt), .jmp_take(jmp_take)
  );

  typedef struct {
    logic [W-1:0] data;
    logic         to_mem;
    string        req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  logic e_gt = 1'b0, e_eq = 1'b1, e_lt = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected item per valid result
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected result", 32'(res_data), 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.req, " data"}, 32'(res_data), 32'(e.data));
        check({e.req, " dest"}, 32'(res_to_mem), 32'(e.to_mem));
      end
    end
  end

  // Driver: apply one operation, then a quiet cycle
  task automatic issue(input logic [2:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] m, input logic en);
    exp_t e;
    @(negedge clk);
    exec_en = en; op_code = op; acc_r = a; mem_opnd = m;
    if (en) begin
      case (op)
        3'd0: begin e.data = m;        e.to_mem = 1'b0; e.req = "R3 load";  exp_q.push_back(e); end
        3'd1: begin e.data = '0;       e.to_mem = 1'b1; e.req = "R4 clear"; exp_q.push_back(e); end
        3'd2: begin e.data = W'(a + m); e.to_mem = 1'b0; e.req = "R2 add";  exp_q.push_back(e); end
        3'd3: begin e.data = W'(a - m); e.to_mem = 1'b0; e.req = "R2 sub";  exp_q.push_back(e); end
        3'd4: begin e.data = W'(m + 1); e.to_mem = 1'b1; e.req = "R4 inc";  exp_q.push_back(e); end
        3'd5: begin e.data = W'(m - 1); e.to_mem = 1'b1; e.req = "R4 dec";  exp_q.push_back(e); end
        3'd6: begin e_gt = (m > a); e_eq = (m == a); e_lt = (m < a); end
        default: ;
      endcase
    end
    @(negedge clk);
    exec_en = 1'b0; op_code = 3'd7;
  endtask

  task automatic check_flags(input string req);
    check({req, " gt"}, 32'(flag_gt), 32'(e_gt));
    check({req, " eq"}, 32'(flag_eq), 32'(e_eq));
    check({req, " lt"}, 32'(flag_lt), 32'(e_lt));
  endtask

  task automatic check_jumps();
    for (int c = 0; c < 8; c++) begin
      logic exp;
      jmp_cond = 3'(c);
      #0.5;
      case (c)
        0: exp = e_gt;
        1: exp = e_eq;
        2: exp = e_lt;
        3: exp = !e_eq;
        4: exp = e_gt | e_eq;
        5: exp = e_lt | e_eq;
        default: exp = 1'b0;
      endcase
      check(c < 3 ? "R7 jump" : "R8 jump", 32'(jmp_take), 32'(exp));
    end
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", 32'(res_valid), 32'd0);
    check_flags("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_jumps();

    // Result-producing operations, with wrap cases
    issue(3'd0, 8'h11, 8'h5A, 1'b1);  check_flags("R6 after load");
    issue(3'd2, 8'd200, 8'd100, 1'b1);
    issue(3'd2, 8'd3, 8'd4, 1'b1);
    issue(3'd3, 8'd10, 8'd20, 1'b1);
    issue(3'd3, 8'd50, 8'd8, 1'b1);
    issue(3'd4, 8'h00, 8'hFF, 1'b1);
    issue(3'd5, 8'h00, 8'h00, 1'b1);
    issue(3'd5, 8'h00, 8'h80, 1'b1);
    issue(3'd1, 8'h33, 8'h77, 1'b1);  check_flags("R6 after clear");
    issue(3'd7, 8'h33, 8'h77, 1'b1);  // R9: no result expected
    issue(3'd2, 8'h01, 8'h01, 1'b0);  // R9: strobe low, no result

    // Compares and branch resolution
    issue(3'd6, 8'd10, 8'd20, 1'b1);  check_flags("R5 greater"); check_jumps();
    issue(3'd6, 8'd42, 8'd42, 1'b1);  check_flags("R5 equal");   check_jumps();
    issue(3'd6, 8'd20, 8'd10, 1'b1);  check_flags("R5 less");    check_jumps();
    issue(3'd6, 8'h00, 8'hFF, 1'b1);  check_flags("R5 unsigned high"); check_jumps();
    issue(3'd6, 8'hFF, 8'h00, 1'b1);  check_flags("R5 unsigned low");  check_jumps();

    // Flags must ignore everything but an executed compare
    issue(3'd6, 8'h05, 8'h09, 1'b0);  check_flags("R6 strobe low");
    issue(3'd2, 8'h05, 8'h05, 1'b1);  check_flags("R6 after add");
    issue(3'd4, 8'h05, 8'h05, 1'b1);  check_flags("R6 after inc");
    check_jumps();

    repeat (3) @(negedge clk);
    check("R9 pending results", 32'(exp_q.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule